// File: doc/BRIEF.md
# Thermometer-Coded Power-of-Two Clock Post Divider

This block sits after a PLL and divides the incoming clock by 1, 2, 4, 8 or 16. The ratio is taken from a field inside a control word. The field is thermometer coded: each extra set bit doubles the ratio. A small priority encoder finds the highest set bit, so a code with holes in it still gives a defined ratio. The block reports the ratio that is currently in force as a plain binary value that software can read back.

Division by one routes the source clock straight to the output through a select path. Every other ratio is taken from a period counter that restarts at each period boundary. That output is high for the first half of the period and low for the second half. A newly written code is sampled only on the edge that ends a full output period, so a ratio change never produces a shortened pulse. A package helper converts a requested ratio into the code to write: the request is rounded up to the next power of two, and the code is that power minus one.

Top module: `thermo_post_div`

## Requirements
- R1: While rst_ni is low, ratio_o reads 1 and clk_o follows clk_i.
- R2: The codes 0x0, 0x1, 0x3, 0x7 and 0xF select ratios 1, 2, 4, 8 and 16, and ratio_o reads the selected ratio.
- R3: A code with gaps decodes from its highest set bit: ratio = 2^(index of top set bit + 1). For example, 0x5 gives 8, 0x2 gives 4, 0x8 gives 16 and 0x9 gives 16.
- R4: With CODE_W=2 the field is two bits wide. Codes 0x0, 0x1 and 0x3 give ratios 1, 2 and 4, and 0x2 gives 4.
- R5: The code is read from ctrl_i[FIELD_LSB +: CODE_W], with FIELD_LSB=8 by default. All other ctrl_i bits have no effect on clk_o or ratio_o.
- R6: A new code is sampled only on the rising clk_i edge that ends the current output period. Both ratio_o and the division change on that edge. A code change in the middle of a period leaves that period untouched.
- R7: For a ratio N ≥ 2, each output period starts at a sampling edge and lasts N clk_i cycles. clk_o is high for the first N/2 cycles and low for the last N/2 cycles.
- R8: For ratio 1, clk_o equals clk_i, and every rising edge is a sampling edge.
- R9: The helper pdiv_pkg::ratio_to_code(req, w) returns (smallest power of two ≥ req) − 1, limited to w bits. A request of 0 or 1 gives 0. For example, 3→0x3, 5→0x7, 9→0xF, 40→0xF with w=4, and 40→0x3 with w=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock from the PLL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | CTRL_W | Control word that holds the thermometer field |
| clk_o | output | 1 | Divided clock |
| ratio_o | output | CODE_W+1 | Ratio currently in force, binary |

## Verification
The assertions assume that ctrl_i is synchronous to clk_i and holds steady around each rising edge. They also assume that nothing but reset disturbs the period counter. The stimulus changes ctrl_i only late in the low phase of clk_i. It fills the bits outside the field with varying junk. One code change is placed deliberately in the middle of a long period. A 4-bit and a 2-bit instance run side by side against a behavioural period model.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;

  // code bit i is set when 2^i is below the request (ceil to power of two, minus one)
  function automatic logic [7:0] ratio_to_code(input int unsigned req, input int unsigned code_w);
    logic [7:0] code;
    code = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < code_w && (32'd1 << i) < req) code[i] = 1'b1;
    end
    return code;
  endfunction

  function automatic int unsigned top_set_pos(input logic [7:0] code, input int unsigned code_w);
    int unsigned pos;
    pos = 0;
    for (int i = 0; i < 8; i++) begin
      if (i < code_w && code[i]) pos = i + 1;
    end
    return pos;
  endfunction

endpackage

// File: rtl/pdiv_thermo_dec.sv
`timescale 1ns/1ps
module pdiv_thermo_dec #(
  parameter int CODE_W  = 4,
  parameter int SHIFT_W = $clog2(CODE_W + 1)
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [SHIFT_W-1:0] shift_o
);
  import pdiv_pkg::*;

  logic [7:0] code_ext;

  always_comb begin
    code_ext = '0;
    code_ext[CODE_W-1:0] = code_i;
    shift_o = SHIFT_W'(top_set_pos(code_ext, CODE_W));
  end

endmodule

// File: rtl/pdiv_period_ctr.sv
`timescale 1ns/1ps
module pdiv_period_ctr #(
  parameter int CODE_W  = 4,
  parameter int SHIFT_W = $clog2(CODE_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SHIFT_W-1:0] shift_new_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [CODE_W-1:0]  cnt_o,
  output logic               div_o,
  output logic               bypass_o
);
  localparam int CNT_W = CODE_W;
  localparam int SPAN_W = CNT_W + 1;

  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q, cnt_inc;
  logic               div_q;
  logic [SPAN_W-1:0]  span, last, half;
  logic               wrap;

  assign span    = SPAN_W'(1) << shift_q;
  assign last    = span - SPAN_W'(1);
  assign half    = span >> 1;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign wrap    = ({1'b0, cnt_q} == last);

  // a new ratio is loaded only where the running period ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      div_q   <= 1'b1;
    end else if (wrap) begin
      shift_q <= shift_new_i;
      cnt_q   <= '0;
      div_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_inc;
      div_q   <= ({1'b0, cnt_inc} < half);
    end
  end

  assign shift_o  = shift_q;
  assign cnt_o    = cnt_q;
  assign div_o    = div_q;
  assign bypass_o = (shift_q == '0);

endmodule

// File: rtl/pdiv_clk_sel.sv
`timescale 1ns/1ps
module pdiv_clk_sel (
  input  logic clk_i,
  input  logic div_i,
  input  logic bypass_i,
  output logic clk_o
);
  // select flips only on a rising clk_i edge at which both legs are high afterwards
  assign clk_o = bypass_i ? clk_i : div_i;

endmodule

// File: rtl/thermo_post_div.sv
`timescale 1ns/1ps
module thermo_post_div #(
  parameter int CTRL_W    = 32,
  parameter int FIELD_LSB = 8,
  parameter int CODE_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              clk_o,
  output logic [CODE_W:0]   ratio_o
);
  localparam int SHIFT_W = $clog2(CODE_W + 1);
  localparam int RATIO_W = CODE_W + 1;

  logic [CODE_W-1:0]  code_w;
  logic [SHIFT_W-1:0] shift_new_w, shift_w;
  logic [CODE_W-1:0]  cnt_w;
  logic               div_w, bypass_w;
  logic               unused_ctrl;

  assign code_w      = ctrl_i[FIELD_LSB +: CODE_W];
  assign unused_ctrl = ^ctrl_i;

  pdiv_thermo_dec #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) u_dec (
    .code_i (code_w),
    .shift_o(shift_new_w)
  );

  pdiv_period_ctr #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_new_i(shift_new_w),
    .shift_o    (shift_w),
    .cnt_o      (cnt_w),
    .div_o      (div_w),
    .bypass_o   (bypass_w)
  );

  pdiv_clk_sel u_sel (
    .clk_i   (clk_i),
    .div_i   (div_w),
    .bypass_i(bypass_w),
    .clk_o   (clk_o)
  );

  assign ratio_o = RATIO_W'(1) << shift_w;

endmodule

// File: rtl/thermo_post_div_chk.sv
`timescale 1ns/1ps
module thermo_post_div_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W:0]   ratio_i,
  input logic [CODE_W-1:0] cnt_i,
  input logic              div_i
);
  AST_RATIO_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ratio_i) == 1); // R2
  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> $stable(ratio_i)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_i} < ratio_i); // R7
  AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != 1 && cnt_i == '0) |-> div_i); // R7
  AST_END_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != 1 && {1'b0, cnt_i} == ratio_i - 1'b1) |-> !div_i); // R7
  AST_BYPASS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == 1) |-> (cnt_i == '0)); // R8

endmodule

bind thermo_post_div thermo_post_div_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ratio_i(ratio_o),
  .cnt_i  (cnt_w),
  .div_i  (div_w)
);

// File: tb/thermo_post_div_bench.sv
`timescale 1ns/1ps
module thermo_post_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_a = '0;
  logic [31:0] ctrl_b = '0;
  logic        clk_a, clk_b;
  logic [4:0]  ratio_a;
  logic [2:0]  ratio_b;

  int total = 0;
  int bad = 0;
  int ma_cnt = 0, ma_ratio = 1;
  int mb_cnt = 0, mb_ratio = 1;

  thermo_post_div #(.CTRL_W(32), .FIELD_LSB(8), .CODE_W(4)) u_thermo_post_div (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl_a), .clk_o(clk_a), .ratio_o(ratio_a)
  );

  thermo_post_div #(.CTRL_W(32), .FIELD_LSB(8), .CODE_W(2)) u_thermo_post_div_w2 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl_b), .clk_o(clk_b), .ratio_o(ratio_b)
  );

  always #2 clk = ~clk;

  function automatic int dec(input int code, input int w);
    int r;
    r = 1;
    for (int i = w - 1; i >= 0; i--) begin
      if (code[i]) begin
        r = 1 << (i + 1);
        break;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_model(inout int cnt, inout int ratio, input int code, input int w);
    if (cnt == ratio - 1) begin
      ratio = dec(code, w);
      cnt = 0;
    end else begin
      cnt++;
    end
  endtask

  function automatic int lvl(input int cnt, input int ratio, input int phase_high);
    if (ratio == 1) return phase_high;
    return (cnt < ratio / 2) ? 1 : 0;
  endfunction

  // one clk period: model update at edge, check high phase, check low phase
  task automatic tick();
    @(posedge clk);
    step_model(ma_cnt, ma_ratio, int'((ctrl_a >> 8) & 32'hF), 4);
    step_model(mb_cnt, mb_ratio, int'((ctrl_b >> 8) & 32'h3), 2);
    #1;
    chk(int'(clk_a) == lvl(ma_cnt, ma_ratio, 1), (ma_ratio == 1) ? "R8" : "R7", int'(clk_a), lvl(ma_cnt, ma_ratio, 1));
    chk(int'(clk_b) == lvl(mb_cnt, mb_ratio, 1), (mb_ratio == 1) ? "R8" : "R7", int'(clk_b), lvl(mb_cnt, mb_ratio, 1));
    chk(int'(ratio_a) == ma_ratio, "R6", int'(ratio_a), ma_ratio);
    chk(int'(ratio_b) == mb_ratio, "R6", int'(ratio_b), mb_ratio);
    #2;
    chk(int'(clk_a) == lvl(ma_cnt, ma_ratio, 0), (ma_ratio == 1) ? "R8" : "R7", int'(clk_a), lvl(ma_cnt, ma_ratio, 0));
    chk(int'(clk_b) == lvl(mb_cnt, mb_ratio, 0), (mb_ratio == 1) ? "R8" : "R7", int'(clk_b), lvl(mb_cnt, mb_ratio, 0));
    #0.5;
  endtask

  task automatic set_codes(input int code_a, input int code_b, input int seed);
    logic [31:0] junk;
    junk = 32'h9E37_79B9 * (seed + 1) ^ 32'h5A5A_C3C3;
    ctrl_a = (junk & ~(32'hF << 8)) | (32'(code_a & 15) << 8);
    ctrl_b = (junk & ~(32'h3 << 8)) | (32'(code_b & 3) << 8);
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seq_a[9] = '{1, 3, 7, 15, 0, 5, 2, 8, 9};
    int seq_b[9] = '{1, 3, 0, 3, 0, 2, 1, 0, 2};
    string tag_a[9] = '{"R2", "R2", "R2", "R2", "R2", "R3", "R3", "R3", "R3"};
    int guard;

    // R1 reset state
    #1;
    chk(ratio_a == 5'd1, "R1", int'(ratio_a), 1);
    chk(ratio_b == 3'd1, "R1", int'(ratio_b), 1);
    @(posedge clk); #1;
    chk(clk_a == 1'b1, "R1", int'(clk_a), 1);
    #2;
    chk(clk_a == 1'b0, "R1", int'(clk_a), 0);
    #0.5;
    rst_n = 1'b1;

    for (int s = 0; s < 9; s++) begin
      set_codes(seq_a[s], seq_b[s], s);
      repeat (40) tick();
      chk(int'(ratio_a) == dec(seq_a[s], 4), tag_a[s], int'(ratio_a), dec(seq_a[s], 4));
      chk(int'(ratio_b) == dec(seq_b[s], 2), "R4", int'(ratio_b), dec(seq_b[s], 2));
    end

    // R5 bits outside the field ignored
    ctrl_a = 32'hFFFF_F1FF;
    ctrl_b = 32'hFFFF_FDFF;
    repeat (40) tick();
    chk(ratio_a == 5'd2, "R5", int'(ratio_a), 2);
    chk(ratio_b == 3'd2, "R5", int'(ratio_b), 2);

    // R6 mid-period change
    set_codes(15, 3, 20);
    repeat (40) tick();
    guard = 0;
    while (ma_cnt != 2 && guard < 40) begin
      tick();
      guard++;
    end
    set_codes(1, 1, 21);
    repeat (3) tick();
    chk(ratio_a == 5'd16, "R6", int'(ratio_a), 16);
    repeat (20) tick();
    chk(ratio_a == 5'd2, "R6", int'(ratio_a), 2);

    // R9 helper
    chk(pdiv_pkg::ratio_to_code(0, 4) == 8'h0, "R9", int'(pdiv_pkg::ratio_to_code(0, 4)), 0);
    chk(pdiv_pkg::ratio_to_code(1, 4) == 8'h0, "R9", int'(pdiv_pkg::ratio_to_code(1, 4)), 0);
    chk(pdiv_pkg::ratio_to_code(2, 4) == 8'h1, "R9", int'(pdiv_pkg::ratio_to_code(2, 4)), 1);
    chk(pdiv_pkg::ratio_to_code(3, 4) == 8'h3, "R9", int'(pdiv_pkg::ratio_to_code(3, 4)), 3);
    chk(pdiv_pkg::ratio_to_code(4, 4) == 8'h3, "R9", int'(pdiv_pkg::ratio_to_code(4, 4)), 3);
    chk(pdiv_pkg::ratio_to_code(5, 4) == 8'h7, "R9", int'(pdiv_pkg::ratio_to_code(5, 4)), 7);
    chk(pdiv_pkg::ratio_to_code(9, 4) == 8'hF, "R9", int'(pdiv_pkg::ratio_to_code(9, 4)), 15);
    chk(pdiv_pkg::ratio_to_code(16, 4) == 8'hF, "R9", int'(pdiv_pkg::ratio_to_code(16, 4)), 15);
    chk(pdiv_pkg::ratio_to_code(40, 4) == 8'hF, "R9", int'(pdiv_pkg::ratio_to_code(40, 4)), 15);
    chk(pdiv_pkg::ratio_to_code(40, 2) == 8'h3, "R9", int'(pdiv_pkg::ratio_to_code(40, 2)), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule